// File: doc/BRIEF.md
# Dual Wiper Register Command Engine

This block keeps the live tap settings of two 64-position digital potentiometers, together with a small bank of preset cells that act as emulated nonvolatile storage. It sits behind a byte-level serial front end. The front end supplies a chip-select level and one strobe for each received byte. The engine decodes the first byte of each selection as a command, then acts on any bytes that follow. It can read or load a wiper, read or program a preset, copy between a wiper and its own presets, and step a wiper up or down. Read results come back on a one-cycle strobe.

A preset is never programmed in the middle of a selection. The command is only armed while chip select is low. Programming begins when chip select returns high, and it then occupies a timed internal write cycle during which `busy` is high and all traffic is ignored. A write-protect input stops preset programming, either at decode time or at any point until chip select rises. Once the write cycle has begun, write-protect has no effect on it. Wiper loads are never protected. The preset cells keep their contents through reset. On leaving reset, each wiper is restored from its preset 0.

Command byte layout: bits [7:4] opcode, bits [3:2] preset index, bit [1] copy direction, bit [0] potentiometer. The opcodes are 0x9 read wiper, 0xA load wiper, 0xB read preset, 0xC program preset, 0xD copy and 0x2 step. FSM states: RECALL, IDLE, OPCODE, DATA, STEP, ARMED, DISCARD, NVWRITE. The transitions are:
- RECALL goes to IDLE.
- IDLE goes to OPCODE when chip select falls.
- OPCODE goes to DATA, STEP, ARMED or DISCARD by decode.
- DATA goes to ARMED or DISCARD.
- ARMED goes to NVWRITE when chip select rises with protect high. It goes to DISCARD or IDLE when protected.
- NVWRITE goes to IDLE or DISCARD when the timer ends.
- Any selecting state goes to IDLE when chip select is high.

Top module: `wiper_cmd_engine`

## Requirements
- R1: While reset is held, `busy` is 1, `rd_valid` is 0 and both taps are 0. On the first clock after release, each tap takes the value of its own preset 0 and `busy` drops.
- R2: Read commands work as follows. Opcode 0x9 returns the selected wiper and 0xB returns the selected preset. The result appears on `rd_data`, zero-extended to 8 bits, with `rd_valid` high for one cycle in the cycle after the opcode byte.
- R3: Opcode 0xA loads bits [5:0] of the next byte into the selected wiper. The other wiper does not change, and `wp_n` has no effect on this load.
- R4: Opcode 0xC followed by a data byte arms a preset write. It starts only when `cs_n` rises with `wp_n` high. `busy` is then high for exactly WRITE_CYCLES cycles, and the new value can be read after that.
- R5: A preset write is cancelled, leaving the preset unchanged and `busy` low, in three cases: `wp_n` is low at decode; `wp_n` falls while `cs_n` is low; or `wp_n` is low in the cycle that `cs_n` rises.
- R6: Once the write cycle has started, changes on `wp_n` do not stop the preset from being updated.
- R7: Opcode 0xD with bit 1 = 0 copies the indexed preset into the wiper at once. With bit 1 = 1, it copies the wiper into the indexed preset through the protected write cycle of R4 and R5.
- R8: After opcode 0x2, each further byte steps the selected wiper by one: up if bit 0 is 1, down if it is 0. The value saturates at 63 and at 0.
- R9: While `busy` is high, no byte changes any wiper or preset. If `cs_n` is still low when the write cycle ends, the rest of that selection is ignored.
- R10: The following bytes are ignored: bytes after an unknown opcode, bytes after a command is complete, and bytes strobed while `cs_n` is high.
- R11: Preset contents survive a reset, so the restore after reset uses the most recently programmed preset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; preset cells are not cleared |
| cs_n | input | 1 | Chip-select level from the serial front end, active low |
| wp_n | input | 1 | Write-protect, active low, guards preset programming |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| tap_sel | output | 12 | Tap selects; potentiometer p at bits [6p+5:6p] |
| rd_valid | output | 1 | One-cycle read-result strobe |
| rd_data | output | 8 | Read result, zero-extended |
| busy | output | 1 | High during the restore cycle and the internal write cycle |

## Verification
Two functions can meet in a single cycle: the rise of chip select that would start programming an armed preset, and a fall of write-protect that should cancel it. The bench drives both edges at the same negedge and expects no busy period and an unchanged preset. It also exercises each one alone: protect falling before the rise, and protect falling after the write cycle has started. Each expected outcome is judged by counting busy cycles and by reading the preset back in a later selection.

// File: rtl/wce_pkg.sv
package wce_pkg;

    localparam int BYTE_W  = 8;
    localparam int OPC_LSB = 4;
    localparam int IDX_LSB = 2;
    localparam int DIR_BIT = 1;
    localparam int POT_BIT = 0;

    typedef enum logic [3:0] {
        OP_STEP      = 4'h2,
        OP_RD_WIPER  = 4'h9,
        OP_WR_WIPER  = 4'hA,
        OP_RD_PRESET = 4'hB,
        OP_WR_PRESET = 4'hC,
        OP_MOVE      = 4'hD
    } op_e;

    typedef enum logic [2:0] {
        S_RECALL,
        S_IDLE,
        S_OPCODE,
        S_DATA,
        S_STEP,
        S_ARMED,
        S_DISCARD,
        S_NVWRITE
    } state_e;

    typedef enum logic [1:0] {
        WOP_HOLD,
        WOP_LOAD,
        WOP_INC,
        WOP_DEC
    } wop_e;

endpackage

// File: rtl/wce_wiper_reg.sv
module wce_wiper_reg #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wce_pkg::wop_e    op,
    input  logic [TAP_W-1:0] load_val,
    output logic [TAP_W-1:0] tap
);
    import wce_pkg::*;

    localparam logic [TAP_W-1:0] TAP_MAX = '1;
    localparam logic [TAP_W-1:0] TAP_MIN = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap <= '0;
        end else begin
            unique case (op)
                WOP_LOAD: tap <= load_val;
                WOP_INC:  if (tap != TAP_MAX) tap <= tap + 1'b1;
                WOP_DEC:  if (tap != TAP_MIN) tap <= tap - 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/wce_preset_bank.sv
module wce_preset_bank #(
    parameter int NPOT  = 2,
    parameter int NDR   = 4,
    parameter int TAP_W = 6,
    parameter int POT_W = 1,
    parameter int IDX_W = 2,
    parameter logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] INIT = '0
) (
    input  logic                               clk,
    input  logic                               we,
    input  logic [POT_W-1:0]                   wr_pot,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [TAP_W-1:0]                   wr_val,
    output logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] cells
);
    // Storage deliberately outside the reset domain: contents persist.
    logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] mem = INIT;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_pot][wr_idx] <= wr_val;
        end
    end

    assign cells = mem;

endmodule

// File: rtl/wce_write_timer.sv
module wce_write_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == CW'(1));

endmodule

// File: rtl/wce_cmd_fsm.sv
module wce_cmd_fsm #(
    parameter int NPOT  = 2,
    parameter int NDR   = 4,
    parameter int TAP_W = 6,
    parameter int POT_W = 1,
    parameter int IDX_W = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cs_n,
    input  logic                                wp_n,
    input  logic                                byte_valid,
    input  logic [wce_pkg::BYTE_W-1:0]          byte_data,
    input  logic                                timer_done,
    input  logic [NPOT-1:0][TAP_W-1:0]          taps,
    input  logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] cells,
    output wce_pkg::wop_e [NPOT-1:0]            wop,
    output logic [NPOT-1:0][TAP_W-1:0]          load_val,
    output logic                                pr_we,
    output logic [POT_W-1:0]                    pr_pot,
    output logic [IDX_W-1:0]                    pr_idx,
    output logic [TAP_W-1:0]                    pr_val,
    output logic                                timer_start,
    output logic                                busy,
    output logic                                rd_valid,
    output logic [wce_pkg::BYTE_W-1:0]          rd_data
);
    import wce_pkg::*;

    state_e state_q, state_d;

    op_e                op_q, op_d;
    logic [POT_W-1:0]   pot_q, pot_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic [TAP_W-1:0]   pend_q, pend_d;
    logic               rdv_d;
    logic [BYTE_W-1:0]  rdd_d;

    // Fields of an incoming command byte
    op_e              b_op;
    logic [POT_W-1:0] b_pot;
    logic [IDX_W-1:0] b_idx;
    logic             b_dir;
    logic             b_take;

    assign b_op   = op_e'(byte_data[OPC_LSB +: 4]);
    assign b_pot  = byte_data[POT_BIT +: POT_W];
    assign b_idx  = byte_data[IDX_LSB +: IDX_W];
    assign b_dir  = byte_data[DIR_BIT];
    assign b_take = byte_valid && !cs_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RECALL;
        end else begin
            state_q <= state_d;
        end
    end

    // Command context and read-result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_STEP;
            pot_q    <= '0;
            idx_q    <= '0;
            pend_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            op_q     <= op_d;
            pot_q    <= pot_d;
            idx_q    <= idx_d;
            pend_q   <= pend_d;
            rd_valid <= rdv_d;
            rd_data  <= rdd_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RECALL: state_d = S_IDLE;
            S_IDLE:   if (!cs_n) state_d = S_OPCODE;
            S_OPCODE: begin
                if (cs_n) begin
                    state_d = S_IDLE;
                end else if (byte_valid) begin
                    case (b_op)
                        OP_WR_WIPER:  state_d = S_DATA;
                        OP_WR_PRESET: state_d = wp_n ? S_DATA : S_DISCARD;
                        OP_MOVE:      state_d = (b_dir && wp_n) ? S_ARMED : S_DISCARD;
                        OP_STEP:      state_d = S_STEP;
                        default:      state_d = S_DISCARD;
                    endcase
                end
            end
            S_DATA: begin
                if (cs_n) begin
                    state_d = S_IDLE;
                end else if (op_q == OP_WR_PRESET && !wp_n) begin
                    state_d = S_DISCARD;
                end else if (byte_valid) begin
                    state_d = (op_q == OP_WR_PRESET) ? S_ARMED : S_DISCARD;
                end
            end
            S_STEP:    if (cs_n) state_d = S_IDLE;
            S_ARMED: begin
                if (cs_n) begin
                    state_d = wp_n ? S_NVWRITE : S_IDLE;
                end else if (!wp_n) begin
                    state_d = S_DISCARD;
                end
            end
            S_DISCARD: if (cs_n) state_d = S_IDLE;
            S_NVWRITE: if (timer_done) state_d = cs_n ? S_IDLE : S_DISCARD;
            default:   state_d = S_IDLE;
        endcase
    end

    // Output and context logic
    always_comb begin
        wop         = {NPOT{WOP_HOLD}};
        load_val    = '0;
        pr_we       = 1'b0;
        timer_start = 1'b0;
        op_d        = op_q;
        pot_d       = pot_q;
        idx_d       = idx_q;
        pend_d      = pend_q;
        rdv_d       = 1'b0;
        rdd_d       = rd_data;

        unique case (state_q)
            S_RECALL: begin
                for (int p = 0; p < NPOT; p++) begin
                    wop[p]      = WOP_LOAD;
                    load_val[p] = cells[p][0];
                end
            end
            S_OPCODE: begin
                if (b_take) begin
                    op_d  = b_op;
                    pot_d = b_pot;
                    idx_d = b_idx;
                    case (b_op)
                        OP_RD_WIPER: begin
                            rdv_d = 1'b1;
                            rdd_d = BYTE_W'(taps[b_pot]);
                        end
                        OP_RD_PRESET: begin
                            rdv_d = 1'b1;
                            rdd_d = BYTE_W'(cells[b_pot][b_idx]);
                        end
                        OP_MOVE: begin
                            if (!b_dir) begin
                                wop[b_pot]      = WOP_LOAD;
                                load_val[b_pot] = cells[b_pot][b_idx];
                            end else begin
                                pend_d = taps[b_pot];
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_DATA: begin
                if (b_take) begin
                    if (op_q == OP_WR_WIPER) begin
                        wop[pot_q]      = WOP_LOAD;
                        load_val[pot_q] = byte_data[TAP_W-1:0];
                    end else begin
                        pend_d = byte_data[TAP_W-1:0];
                    end
                end
            end
            S_STEP: begin
                if (b_take) begin
                    wop[pot_q] = byte_data[0] ? WOP_INC : WOP_DEC;
                end
            end
            S_ARMED:   timer_start = cs_n && wp_n;
            S_NVWRITE: pr_we = timer_done;
            default:   ;
        endcase
    end

    assign pr_pot = pot_q;
    assign pr_idx = idx_q;
    assign pr_val = pend_q;
    assign busy   = (state_q == S_NVWRITE) || (state_q == S_RECALL);

endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine #(
    parameter int NPOT         = 2,
    parameter int NDR          = 4,
    parameter int TAP_W        = 6,
    parameter int WRITE_CYCLES = 16,
    parameter logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] PRESET_INIT = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  wp_n,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    output logic [NPOT*TAP_W-1:0] tap_sel,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output logic                  busy
);
    import wce_pkg::*;

    localparam int POT_W = (NPOT > 1) ? $clog2(NPOT) : 1;
    localparam int IDX_W = (NDR > 1) ? $clog2(NDR) : 1;

    logic [NPOT-1:0][TAP_W-1:0]          taps;
    logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] cells;
    wop_e [NPOT-1:0]                     wop;
    logic [NPOT-1:0][TAP_W-1:0]          load_val;
    logic                                pr_we;
    logic [POT_W-1:0]                    pr_pot;
    logic [IDX_W-1:0]                    pr_idx;
    logic [TAP_W-1:0]                    pr_val;
    logic                                timer_start;
    logic                                timer_done;

    wce_cmd_fsm #(
        .NPOT(NPOT), .NDR(NDR), .TAP_W(TAP_W), .POT_W(POT_W), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .timer_done(timer_done), .taps(taps), .cells(cells),
        .wop(wop), .load_val(load_val),
        .pr_we(pr_we), .pr_pot(pr_pot), .pr_idx(pr_idx), .pr_val(pr_val),
        .timer_start(timer_start), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_wiper
        wce_wiper_reg #(.TAP_W(TAP_W)) u_wiper (
            .clk(clk), .rst_n(rst_n), .op(wop[p]),
            .load_val(load_val[p]), .tap(taps[p])
        );
        assign tap_sel[p*TAP_W +: TAP_W] = taps[p];
    end

    wce_preset_bank #(
        .NPOT(NPOT), .NDR(NDR), .TAP_W(TAP_W),
        .POT_W(POT_W), .IDX_W(IDX_W), .INIT(PRESET_INIT)
    ) u_bank (
        .clk(clk), .we(pr_we), .wr_pot(pr_pot), .wr_idx(pr_idx),
        .wr_val(pr_val), .cells(cells)
    );

    wce_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .done(timer_done)
    );

endmodule

// File: rtl/wce_checker.sv
module wce_checker #(
    parameter int NPOT  = 2,
    parameter int TAP_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  wp_n,
    input logic                  busy,
    input logic                  rd_valid,
    input logic [7:0]            rd_data,
    input logic [NPOT*TAP_W-1:0] tap_sel
);

    // A write cycle only begins after chip select was high
    assert_start_on_cs_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_n));

    // A write cycle never begins while protect is low
    assert_no_start_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    // Wipers frozen throughout a busy period
    assert_wipers_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tap_sel));

    // No read result during a busy period
    assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_valid);

    // Read strobe lasts one cycle
    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // Read result is zero-extended
    assert_read_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[7:TAP_W] == '0));

endmodule

bind wiper_cmd_engine wce_checker #(.NPOT(NPOT), .TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .tap_sel(tap_sel)
);

// File: tb/sim_wiper_cmd_engine.sv
module sim_wiper_cmd_engine;

    localparam int TAP_W = 6;
    localparam int NPOT  = 2;
    localparam int NDR   = 4;
    localparam int WC    = 12;
    localparam logic [NPOT-1:0][NDR-1:0][TAP_W-1:0] INIT =
        {6'd33, 6'd17, 6'd0, 6'd42, 6'd63, 6'd40, 6'd5, 6'd21};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wp_n = 1'b1;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [NPOT*TAP_W-1:0] tap_sel;
    logic rd_valid;
    logic [7:0] rd_data;
    logic busy;

    always #5 clk = ~clk;

    wiper_cmd_engine #(
        .NPOT(NPOT), .NDR(NDR), .TAP_W(TAP_W),
        .WRITE_CYCLES(WC), .PRESET_INIT(INIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .tap_sel(tap_sel), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_tap [NPOT];
    int m_pre [NPOT][NDR];
    int rd_seen;
    int rd_val;
    int bc;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int step_sat(int v, bit up);
        if (up) return (v == 63) ? 63 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    function automatic logic [7:0] opc(logic [3:0] op, int idx, bit dir, int pot);
        return {op, 2'(idx), dir, 1'(pot)};
    endfunction

    task automatic put(logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        rd_seen    = int'(rd_valid);
        rd_val     = int'(rd_data);
    endtask

    task automatic open_frame();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic close_frame(output int cycles);
        @(negedge clk);
        cs_n = 1'b1;
        cycles = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy) break;
            cycles++;
        end
    endtask

    task automatic check_taps(string req);
        for (int p = 0; p < NPOT; p++)
            chk(req, int'(tap_sel[p*TAP_W +: TAP_W]), m_tap[p]);
    endtask

    task automatic read_wiper(int p, string req);
        int c;
        open_frame();
        put(opc(4'h9, 0, 1'b0, p));
        chk(req, rd_seen, 1);
        chk(req, rd_val, m_tap[p]);
        close_frame(c);
    endtask

    task automatic read_preset(int p, int d, string req);
        int c;
        open_frame();
        put(opc(4'hB, d, 1'b0, p));
        chk(req, rd_seen, 1);
        chk(req, rd_val, m_pre[p][d]);
        close_frame(c);
    endtask

    task automatic load_wiper(int p, int v);
        int c;
        open_frame();
        put(opc(4'hA, 0, 1'b0, p));
        put(8'(v));
        close_frame(c);
        m_tap[p] = v;
    endtask

    // scen: 0 protect at decode, 1 protect falls while selected,
    // 2 protect falls with chip-select rise, other values commit
    task automatic nv_cmd(bit from_wiper, int p, int d, int v, int scen);
        bit ok;
        ok = (scen >= 3);
        if (scen == 0) wp_n = 1'b0;
        open_frame();
        if (from_wiper) begin
            put(opc(4'hD, d, 1'b1, p));
            v = m_tap[p];
        end else begin
            put(opc(4'hC, d, 1'b0, p));
            put(8'(v));
        end
        if (scen == 1) begin @(negedge clk); wp_n = 1'b0; end
        if (scen == 2) begin @(negedge clk); wp_n = 1'b0; cs_n = 1'b1; end
        close_frame(bc);
        wp_n = 1'b1;
        if (ok) begin
            chk(from_wiper ? "R7" : "R4", bc, WC);
            m_pre[p][d] = v;
        end else begin
            chk("R5", bc, 0);
        end
    endtask

    task automatic step_frame(int p, int n, int dirs);
        int c;
        open_frame();
        put(opc(4'h2, 0, 1'b0, p));
        for (int k = 0; k < n; k++) begin
            put({7'h0, dirs[k]});
            m_tap[p] = step_sat(m_tap[p], dirs[k]);
        end
        close_frame(c);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int c;
        int seed;
        seed = $urandom(20240611);
        for (int p = 0; p < NPOT; p++)
            for (int d = 0; d < NDR; d++) m_pre[p][d] = int'(INIT[p][d]);

        // R1: reset state, then restore
        repeat (3) @(negedge clk);
        chk("R1", int'(busy), 1);
        chk("R1", int'(rd_valid), 0);
        chk("R1", int'(tap_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NPOT; p++) m_tap[p] = m_pre[p][0];
        check_taps("R1");
        chk("R1", int'(busy), 0);

        // R2: read back every preset and both wipers
        for (int p = 0; p < NPOT; p++) begin
            read_wiper(p, "R2");
            for (int d = 0; d < NDR; d++) read_preset(p, d, "R2");
        end

        // R3 and R10: load under protect, with a trailing junk byte
        wp_n = 1'b0;
        open_frame();
        put(opc(4'hA, 0, 1'b0, 0));
        put(8'hF2);
        put(8'h17);
        close_frame(c);
        wp_n = 1'b1;
        m_tap[0] = 50;
        check_taps("R3");

        // R8: saturation at both ends
        load_wiper(1, 62);
        step_frame(1, 3, 32'b111);
        chk("R8", int'(tap_sel[TAP_W +: TAP_W]), 63);
        load_wiper(0, 1);
        step_frame(0, 3, 32'b000);
        chk("R8", int'(tap_sel[0 +: TAP_W]), 0);
        step_frame(0, 4, 32'b0101);
        check_taps("R8");

        // R4: commit then read back
        nv_cmd(1'b0, 1, 2, 7, 3);
        read_preset(1, 2, "R4");

        // R5: three cancel cases
        for (int s = 0; s < 3; s++) begin
            nv_cmd(1'b0, 0, 1, 60 - s, s);
            read_preset(0, 1, "R5");
        end

        // R6: protect falls during the write cycle
        open_frame();
        put(opc(4'hC, 3, 1'b0, 0));
        put(8'd9);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); wp_n = 1'b0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        wp_n = 1'b1;
        m_pre[0][3] = 9;
        read_preset(0, 3, "R6");

        // R9: traffic during busy and after busy in the same selection
        open_frame();
        put(opc(4'hC, 2, 1'b0, 0));
        put(8'd11);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        put(opc(4'hA, 0, 1'b0, 1));
        put(8'd3);
        chk("R9", int'(busy), 1);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        put(opc(4'hA, 0, 1'b0, 1));
        put(8'd4);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check_taps("R9");
        m_pre[0][2] = 11;
        read_preset(0, 2, "R9");

        // R7: copies both ways
        open_frame();
        put(opc(4'hD, 3, 1'b0, 0));
        close_frame(c);
        m_tap[0] = m_pre[0][3];
        check_taps("R7");
        nv_cmd(1'b1, 1, 1, 0, 4);
        read_preset(1, 1, "R7");

        // R10: unknown opcode, byte with chip select high
        open_frame();
        put(8'h51);
        put(8'h2A);
        close_frame(c);
        put(opc(4'hA, 0, 1'b0, 0));
        put(8'd1);
        check_taps("R10");

        // R11: program preset 0, reset, restore from it
        nv_cmd(1'b0, 0, 0, 44, 5);
        nv_cmd(1'b0, 1, 0, 13, 5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NPOT; p++) m_tap[p] = m_pre[p][0];
        check_taps("R11");

        // Random mix
        for (int it = 0; it < 160; it++) begin
            int kind, p, d, v;
            kind = int'($urandom % 7);
            p = int'($urandom % NPOT);
            d = int'($urandom % NDR);
            v = int'($urandom % 64);
            case (kind)
                0: read_wiper(p, "R2");
                1: read_preset(p, d, "R2");
                2: begin
                    wp_n = $urandom % 2 == 0;
                    load_wiper(p, v);
                    wp_n = 1'b1;
                    check_taps("R3");
                end
                3: nv_cmd(1'b0, p, d, v, int'($urandom % 6));
                4: begin
                    open_frame();
                    put(opc(4'hD, d, 1'b0, p));
                    close_frame(c);
                    m_tap[p] = m_pre[p][d];
                    check_taps("R7");
                end
                5: nv_cmd(1'b1, p, d, 0, int'($urandom % 6));
                default: begin
                    step_frame(p, 1 + int'($urandom % 8), int'($urandom));
                    check_taps("R8");
                end
            endcase
        end
        for (int p = 0; p < NPOT; p++)
            for (int d = 0; d < NDR; d++) read_preset(p, d, "R4");

        summary();
        $finish;
    end

endmodule